// File: doc/BRIEF.md
# Read-Data Acceptance with Retry Cancellation

This block sits on the read-data receive path of a bus master and decides when a data beat returned on the bus may be handed to the core. A strap captured as hard reset is released picks one of two modes. In held mode, every acknowledged beat is kept in a register for one bus cycle. During that cycle either retry input can still withdraw it. Only a beat that survives is passed on. In fast mode, an acknowledged beat goes to the core in the cycle it is acknowledged. Any retry that comes too late to be honoured is recorded in a sticky protocol-error flag.

Reads are bursts of `BURST_LEN` beats (four by default). A beat index counts the beats accepted so far. A beat withdrawn by data retry is not counted, and its re-acknowledgement is accepted under the same index. An address retry aborts the whole burst, asks the core to reissue the request, and sends the index back to zero. A done pulse marks the last accepted beat of a burst.

The controller is a four-state machine. States: `S_NWAIT` (held mode, nothing held), `S_NHOLD` (held mode, one beat held), `S_FWAIT` (fast mode, waiting for data) and `S_FCHK` (fast mode, the cycle after the first beat of a burst).

Transitions:
- `S_NWAIT` to `S_NHOLD` on acknowledge.
- `S_NHOLD` stays in `S_NHOLD` when a new acknowledge arrives, whether or not the held beat was forwarded or retried.
- `S_NHOLD` to `S_NWAIT` when no acknowledge arrives, and always on address retry.
- `S_FWAIT` to `S_FCHK` on an acknowledge at beat index zero, unless address retry is also active.
- `S_FCHK` to `S_FWAIT` unconditionally.
- While hard reset is active, the state is loaded with `S_FWAIT` or `S_NWAIT` according to the strap.

Top module: `rdacc_top`

## Requirements
- R1: `fast_mode` takes the value `bus_dretry` had in the last cycle in which `hard_rst` was high (1 = fast mode, 0 = held mode).
- R2: In held mode, a beat acknowledged in cycle n appears on `core_data` with `core_valid` high in cycle n+1, provided neither retry is active in cycle n+1. `core_valid` is low in cycle n.
- R3: In held mode, `bus_dretry` in cycle n+1 discards the held beat. `core_valid` stays low and the beat index does not advance, so the next acknowledged beat is accepted with the same `core_beat`.
- R4: In held mode, `bus_aretry` in cycle n+1 discards the held beat and pulses `reissue_req` in that cycle. The next accepted beat has `core_beat` = 0. `bus_aretry` takes priority when both retries are active.
- R5: In held mode, back-to-back acknowledges stream: each beat is forwarded exactly one cycle after its acknowledge.
- R6: In fast mode, `core_valid` is high in the same cycle as `bus_ack`, with `core_data` equal to `bus_data`. This is one cycle less latency than held mode.
- R7: In fast mode, any `bus_dretry` after reset sets `proto_err` from the next cycle on. The flag stays set until `hard_rst`.
- R8: In fast mode, `bus_aretry` in the cycle right after the first acknowledge of a burst sets `proto_err`. `bus_aretry` in any other cycle aborts the burst with `reissue_req` and sets no error.
- R9: `core_beat` reports 0 to `BURST_LEN`-1 for accepted beats. `burst_done` pulses together with `core_valid` on the beat at index `BURST_LEN`-1.
- R10: Outside reset, `bus_dretry` does not change `fast_mode`. In held mode, `bus_dretry` with no beat held has no effect on any output.
- R11: `proto_err` is never set in held mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| hard_rst | input | 1 | Synchronous hard reset, active high; its release captures the mode strap |
| bus_ack | input | 1 | Transfer acknowledge for the beat on `bus_data` |
| bus_dretry | input | 1 | Data retry; also the mode strap during reset |
| bus_aretry | input | 1 | Address retry |
| bus_data | input | DATA_W | Read data from the bus |
| core_valid | output | 1 | A beat is delivered to the core this cycle |
| core_data | output | DATA_W | Delivered beat |
| core_beat | output | CNT_W | Index of the delivered beat in its burst |
| burst_done | output | 1 | Last beat of the burst delivered |
| reissue_req | output | 1 | Burst aborted; core must reissue the request |
| fast_mode | output | 1 | 1 when fast mode was strapped |
| proto_err | output | 1 | Sticky late-retry protocol error |

## Verification
The bench walks through every combination of cancel position within a burst and cancel kind (none, data retry, address retry, both). A design that advanced the index on a withdrawn beat would report the retried beat at the wrong `core_beat`. A design that forgot to clear the index on address retry would end the reissued burst early. Streaming acknowledges catch a hold stage that drops or duplicates a beat when a new beat arrives while the old one is being released. In fast mode, the bench puts an address retry right after the first beat and again after the second; a checker keyed to the wrong cycle either misses the error or flags a legal abort. The strap is toggled across several resets, with the opposite level held earlier in reset, to catch a mode register that samples too early or keeps tracking after release.

// File: rtl/rdacc_pkg.sv
package rdacc_pkg;
    typedef enum logic [1:0] {
        S_NWAIT = 2'd0,
        S_NHOLD = 2'd1,
        S_FWAIT = 2'd2,
        S_FCHK  = 2'd3
    } rdacc_state_e;
endpackage

// File: rtl/rdacc_beat_cnt.sv
module rdacc_beat_cnt #(
    parameter int BURST_LEN = 4,
    localparam int CNT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    assign last = (cnt_q == CNT_W'(BURST_LEN - 1));
    assign cnt  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
    end

    // R9
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        (32'(cnt_q) < BURST_LEN));

    // R4
    cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0));
endmodule

// File: rtl/rdacc_hold_reg.sv
module rdacc_hold_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/rdacc_err_mon.sv
module rdacc_err_mon (
    input  logic clk,
    input  logic rst,
    input  logic set,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end
    end

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        flag |=> flag);
endmodule

// File: rtl/rdacc_top.sv
module rdacc_top #(
    parameter int DATA_W    = 32,
    parameter int BURST_LEN = 4,
    localparam int CNT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
    input  logic              clk,
    input  logic              hard_rst,
    input  logic              bus_ack,
    input  logic              bus_dretry,
    input  logic              bus_aretry,
    input  logic [DATA_W-1:0] bus_data,
    output logic              core_valid,
    output logic [DATA_W-1:0] core_data,
    output logic [CNT_W-1:0]  core_beat,
    output logic              burst_done,
    output logic              reissue_req,
    output logic              fast_mode,
    output logic              proto_err
);
    import rdacc_pkg::*;

    rdacc_state_e state_q, state_d;
    logic mode_q;
    logic fwd, cnt_inc, cnt_clr, hold_ld, reiss, err_set;
    logic [CNT_W-1:0] cnt;
    logic cnt_last;
    logic [DATA_W-1:0] held;

    // state register; the strap is sampled on every reset cycle
    always_ff @(posedge clk) begin
        if (hard_rst) begin
            mode_q  <= bus_dretry;
            state_q <= bus_dretry ? S_FWAIT : S_NWAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state and control decode
    always_comb begin
        state_d = state_q;
        fwd     = 1'b0;
        cnt_inc = 1'b0;
        cnt_clr = 1'b0;
        hold_ld = 1'b0;
        reiss   = 1'b0;
        err_set = 1'b0;
        unique case (state_q)
            S_NWAIT: begin
                if (bus_ack) begin
                    hold_ld = 1'b1;
                    state_d = S_NHOLD;
                end
            end
            S_NHOLD: begin
                if (bus_aretry) begin
                    reiss   = 1'b1;
                    cnt_clr = 1'b1;
                    state_d = S_NWAIT;
                end else begin
                    if (!bus_dretry) begin
                        fwd     = 1'b1;
                        cnt_inc = 1'b1;
                    end
                    if (bus_ack) begin
                        hold_ld = 1'b1;
                        state_d = S_NHOLD;
                    end else begin
                        state_d = S_NWAIT;
                    end
                end
            end
            S_FWAIT: begin
                err_set = bus_dretry;
                if (bus_aretry) begin
                    reiss   = 1'b1;
                    cnt_clr = 1'b1;
                end else if (bus_ack) begin
                    fwd     = 1'b1;
                    cnt_inc = 1'b1;
                    if (cnt == '0) begin
                        state_d = S_FCHK;
                    end
                end
            end
            S_FCHK: begin
                err_set = bus_dretry || bus_aretry;
                if (bus_ack) begin
                    fwd     = 1'b1;
                    cnt_inc = 1'b1;
                end
                state_d = S_FWAIT;
            end
            default: state_d = S_NWAIT;
        endcase
    end

    // outputs
    always_comb begin
        core_valid  = fwd;
        core_data   = mode_q ? bus_data : held;
        core_beat   = cnt;
        burst_done  = fwd && cnt_last;
        reissue_req = reiss;
        fast_mode   = mode_q;
    end

    rdacc_beat_cnt #(.BURST_LEN(BURST_LEN)) u_cnt (
        .clk  (clk),
        .rst  (hard_rst),
        .inc  (cnt_inc),
        .clr  (cnt_clr),
        .cnt  (cnt),
        .last (cnt_last)
    );

    rdacc_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk  (clk),
        .rst  (hard_rst),
        .load (hold_ld),
        .d    (bus_data),
        .q    (held)
    );

    rdacc_err_mon u_err (
        .clk  (clk),
        .rst  (hard_rst),
        .set  (err_set),
        .flag (proto_err)
    );

    // R2
    held_beat_chk: assert property (@(posedge clk) disable iff (hard_rst)
        (!fast_mode && core_valid) |-> $past(bus_ack));

    // R6
    fast_same_cycle_chk: assert property (@(posedge clk) disable iff (hard_rst)
        (fast_mode && core_valid) |-> bus_ack);

    // R7
    dretry_flag_chk: assert property (@(posedge clk) disable iff (hard_rst)
        (fast_mode && bus_dretry) |=> proto_err);

    // R9
    done_last_chk: assert property (@(posedge clk) disable iff (hard_rst)
        burst_done |-> (core_valid && core_beat == CNT_W'(BURST_LEN - 1)));

    // R4
    reissue_zero_chk: assert property (@(posedge clk) disable iff (hard_rst)
        reissue_req |=> (core_beat == '0));

    // R10
    mode_hold_chk: assert property (@(posedge clk) disable iff (hard_rst)
        !$past(hard_rst) |-> $stable(fast_mode));

    // R11
    normal_no_err_chk: assert property (@(posedge clk) disable iff (hard_rst)
        !fast_mode |-> !proto_err);
endmodule

// File: tb/tb_rdacc_top.sv
module tb_rdacc_top;
    localparam int DW = 32;
    localparam int BL = 4;
    localparam int CW = 2;

    logic clk = 1'b0;
    logic hard_rst = 1'b1;
    logic ack = 1'b0, dr = 1'b0, ar = 1'b0;
    logic [DW-1:0] d = '0;
    logic core_valid, burst_done, reissue_req, fast_mode, proto_err;
    logic [DW-1:0] core_data;
    logic [CW-1:0] core_beat;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    rdacc_top #(.DATA_W(DW), .BURST_LEN(BL)) dut (
        .clk(clk), .hard_rst(hard_rst), .bus_ack(ack), .bus_dretry(dr),
        .bus_aretry(ar), .bus_data(d), .core_valid(core_valid),
        .core_data(core_data), .core_beat(core_beat), .burst_done(burst_done),
        .reissue_req(reissue_req), .fast_mode(fast_mode), .proto_err(proto_err)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // drive after a falling edge, then settle before sampling
    task automatic step(logic a, logic rd, logic ra, logic [DW-1:0] v);
        ack = a; dr = rd; ar = ra; d = v;
        #2;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset(logic s);
        @(negedge clk);
        hard_rst = 1'b1; ack = 0; ar = 0; dr = ~s;
        tick(); tick();
        dr = s;
        tick();
        hard_rst = 1'b0; dr = 1'b0;
        #2;
        chk("R1 fast_mode after strap", 32'(fast_mode), 32'(s));
        chk("R1 valid low after reset", 32'(core_valid), 0);
        chk("R7 err clear after reset", 32'(proto_err), 0);
        tick();
    endtask

    // held mode, one beat at a time; kind 0 none, 1 dretry, 2 aretry, 3 both
    task automatic normal_burst(int cpos, int kind);
        int b = 0;
        int att = 0;
        bit used = 0;
        logic [DW-1:0] v;
        while (b < BL) begin
            v = {8'hA5, 8'(cpos), 8'(kind), 4'(b), 4'(att)};
            step(1, 0, 0, v);
            chk("R2 no valid in ack cycle", 32'(core_valid), 0);
            tick();
            att++;
            if (!used && b == cpos && kind != 0) begin
                used = 1;
                step(0, kind[0], kind[1], '0);
                chk("R3 cancelled beat not forwarded", 32'(core_valid), 0);
                chk("R4 reissue on address retry", 32'(reissue_req), 32'(kind >= 2));
                if (kind >= 2) b = 0;
            end else begin
                step(0, 0, 0, '0);
                chk("R2 held beat forwarded", 32'(core_valid), 1);
                chk("R2 held beat data", core_data, v);
                chk("R3 R4 R9 beat index", 32'(core_beat), 32'(b));
                chk("R9 done on last beat", 32'(burst_done), 32'(b == BL - 1));
                b++;
            end
            tick();
        end
    endtask

    initial begin
        #4_000_000;
        if (!finished) begin
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // strap sweep, R1
        for (int s = 0; s < 2; s++) begin
            do_reset(s[0]);
            do_reset(~s[0]);
        end

        do_reset(1'b0);
        // R10: idle dretry in held mode is inert
        step(0, 1, 0, 32'h1234);
        chk("R10 idle dretry no valid", 32'(core_valid), 0);
        chk("R10 idle dretry no reissue", 32'(reissue_req), 0);
        tick();
        step(0, 0, 0, '0);
        chk("R10 mode unchanged by dretry", 32'(fast_mode), 0);
        chk("R11 no err in held mode", 32'(proto_err), 0);
        tick();

        // cancel position x kind sweep, R3 R4
        for (int k = 0; k < 4; k++)
            for (int p = 0; p < BL; p++)
                normal_burst(p, k);
        chk("R11 no err after retries", 32'(proto_err), 0);

        // R5 streaming
        for (int k = 0; k <= BL; k++) begin
            step(k < BL, 0, 0, 32'hB0 + k);
            chk("R5 stream valid", 32'(core_valid), 32'(k > 0));
            if (k > 0) begin
                chk("R5 stream data", core_data, 32'hB0 + k - 1);
                chk("R5 stream index", 32'(core_beat), 32'(k - 1));
                chk("R9 stream done", 32'(burst_done), 32'(k == BL));
            end
            tick();
        end
        step(0, 0, 0, '0);
        tick();

        // fast mode burst, R6 R9
        do_reset(1'b1);
        for (int b = 0; b < BL; b++) begin
            step(1, 0, 0, 32'hC0 + b);
            chk("R6 same-cycle valid", 32'(core_valid), 1);
            chk("R6 same-cycle data", core_data, 32'hC0 + b);
            chk("R9 fast index", 32'(core_beat), 32'(b));
            chk("R9 fast done", 32'(burst_done), 32'(b == BL - 1));
            tick();
        end
        step(0, 0, 0, '0);
        chk("R8 no err on clean burst", 32'(proto_err), 0);
        tick();

        // R8 late address retry after first ack
        step(1, 0, 0, 32'hD0);
        tick();
        step(0, 0, 1, '0);
        tick();
        step(0, 0, 0, '0);
        chk("R8 late aretry flagged", 32'(proto_err), 1);
        tick(); tick();
        step(0, 0, 0, '0);
        chk("R7 err sticky", 32'(proto_err), 1);
        tick();

        // R8 legal abort after second beat
        do_reset(1'b1);
        step(1, 0, 0, 32'hE0); tick();
        step(1, 0, 0, 32'hE1); tick();
        step(0, 0, 1, '0);
        chk("R8 legal abort reissue", 32'(reissue_req), 1);
        chk("R8 abort forwards nothing", 32'(core_valid), 0);
        tick();
        step(1, 0, 0, 32'hE2);
        chk("R8 no err on legal abort", 32'(proto_err), 0);
        chk("R4 index zero after abort", 32'(core_beat), 0);
        tick();

        // R7 dretry in fast mode
        do_reset(1'b1);
        step(0, 1, 0, '0); tick();
        step(0, 0, 0, '0);
        chk("R7 dretry flagged", 32'(proto_err), 1);
        chk("R10 mode kept after dretry", 32'(fast_mode), 1);
        tick();
        do_reset(1'b0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule